// File: doc/BRIEF.md
# Configurable Kick-Restarted Watchdog Timer

This block is a hardware watchdog driven entirely through one byte-wide control register. The low three bits hold a setting code. Depending on a build-time table variant, the code selects a pair made of an initial delay and a regular timeout, both counted in whole seconds. Alternatively the code switches the watchdog off. Bit 3 is the kick bit. Software restarts the timeout by writing the register once with that bit set and then again with it clear. Bits 7 to 4 are stored but have no function. A read always returns the last byte written, so software can use read-modify-write.

A prescaler turns a parameterised number of clock cycles into one second of watchdog time. Simulation can therefore run with a very short "second". If the running timeout reaches zero, the block drives its reset output high for a parameterised number of cycles. It then re-enters the initial-delay phase of the setting that is still programmed. A setting with zero initial delay does not count at all until the first kick arrives. A change of setting code restarts the whole sequence with the new pair.

Top module: `hb_watchdog`

## Requirements
- R1: After reset, rdData reads 8'h03 (code 3, watchdog off) and wdReset is low.
- R2: One cycle after a write, rdData equals the whole byte written, including bits 7 to 4.
- R3: Code 3 and every code that the selected table does not list keep wdReset low indefinitely. Writing such a code stops all counting.
- R4: When a code with nonzero initial delay D is written, wdReset rises exactly D*TICKS_PER_SEC cycles after the write edge, unless a kick or a code change happens first.
- R5: A kick is a write that clears bit 3 while the stored bit 3 is 1. It restarts counting with the regular timeout T, and wdReset rises T*TICKS_PER_SEC cycles after the clearing write. A write that only sets bit 3 has no effect on the timing.
- R6: For a code with zero initial delay, no reset occurs until the first kick. The first kick starts the regular timeout. After an expiry the block again waits for a kick.
- R7: Every expiry holds wdReset high for exactly RESET_CYCLES cycles. For a nonzero-delay code, the next expiry without a kick comes D*TICKS_PER_SEC cycles after the pulse ends.
- R8: A write that changes the code while the watchdog is counting restarts the sequence with the initial delay of the new code.
- R9: VARIANT=1 (table C) uses code to (delay, timeout) in seconds: 1 is (3,3), 2 is (60,1), 5 is (0,1), 6 is (0,10), 7 is (60,10). VARIANT=0 (table A) uses 5 is (1,1), 6 is (10,10), 7 is (60,60). All other codes are off.
- R10: Writing code 3 while wdReset is high drops wdReset in the next cycle, and no further reset follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe for the control register |
| wrData | input | 8 | Byte to store: [2:0] setting code, [3] kick bit, [7:4] spare |
| rdData | output | 8 | Current contents of the control register |
| wdReset | output | 1 | Active-high reset pulse on watchdog expiry |

## Verification
A wrong phase or counter value shows up at wdReset as a rise on the wrong cycle. Examples are a delay loaded where a timeout belongs, or a kick missed or taken on the setting write. It can also show up as a rise where none should occur, such as after a disable or in the wait for a kick. The bench predicts the exact rise cycle and the pulse width of every expiry. A stale phase is therefore exposed at the first expiry after the fault, within at most 60 seconds of watchdog time. Register faults show on rdData one cycle after the write.

// File: rtl/hbw_pkg.sv
package hbw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_DELAY,
    ST_RUN,
    ST_FIRE
  } wdState_t;

  typedef struct packed {
    logic       en;
    logic [5:0] delaySec;
    logic [5:0] toutSec;
  } wdPair_t;

  typedef struct packed {
    logic loadDelay;
    logic loadTout;
    logic runCnt;
    logic loadPulse;
    logic decPulse;
  } wdStrobe_t;

  typedef struct packed {
    logic kickEdge;
    logic cfgChange;
    logic nextEn;
    logic nextDelayZero;
    logic secDone;
    logic pulseDone;
    logic cfgEn;
  } wdStatus_t;

  localparam logic [7:0] CTRL_RESET = 8'h03;

  function automatic wdPair_t mkPair(input logic [5:0] d, input logic [5:0] t);
    wdPair_t p;
    p.en       = 1'b1;
    p.delaySec = d;
    p.toutSec  = t;
    return p;
  endfunction

  function automatic wdPair_t pairA(input logic [2:0] code);
    wdPair_t p;
    p = '0;
    case (code)
      3'd5:    p = mkPair(6'd1, 6'd1);
      3'd6:    p = mkPair(6'd10, 6'd10);
      3'd7:    p = mkPair(6'd60, 6'd60);
      default: p = '0;
    endcase
    return p;
  endfunction

  function automatic wdPair_t pairC(input logic [2:0] code);
    wdPair_t p;
    p = '0;
    case (code)
      3'd1:    p = mkPair(6'd3, 6'd3);
      3'd2:    p = mkPair(6'd60, 6'd1);
      3'd5:    p = mkPair(6'd0, 6'd1);
      3'd6:    p = mkPair(6'd0, 6'd10);
      3'd7:    p = mkPair(6'd60, 6'd10);
      default: p = '0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/hbw_datapath.sv
module hbw_datapath
  import hbw_pkg::*;
#(
  parameter int TICKS_PER_SEC = 1000,
  parameter int RESET_CYCLES  = 16,
  parameter int VARIANT       = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  wdStrobe_t  strobe,
  output wdStatus_t  status,
  output logic [7:0] rdData
);

  localparam int PRE_W   = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam int PULSE_W = (RESET_CYCLES > 1) ? $clog2(RESET_CYCLES + 1) : 1;
  localparam logic [PRE_W-1:0]   PRE_LAST   = PRE_W'(TICKS_PER_SEC - 1);
  localparam logic [PULSE_W-1:0] PULSE_INIT = PULSE_W'(RESET_CYCLES - 1);

  logic [7:0]         ctrlReg;
  logic [2:0]         nextCode;
  wdPair_t            curPair;
  wdPair_t            nextPair;
  logic [PRE_W-1:0]   preCnt;
  logic [5:0]         secCnt;
  logic [PULSE_W-1:0] pulseCnt;
  logic               preWrap;

  // control register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ctrlReg <= CTRL_RESET;
    else if (wrEn) ctrlReg <= wrData;
  end

  assign rdData   = ctrlReg;
  assign nextCode = wrEn ? wrData[2:0] : ctrlReg[2:0];

  // timeout table variant
  generate
    if (VARIANT == 1) begin : g_tableC
      assign curPair  = pairC(ctrlReg[2:0]);
      assign nextPair = pairC(nextCode);
    end else begin : g_tableA
      assign curPair  = pairA(ctrlReg[2:0]);
      assign nextPair = pairA(nextCode);
    end
  endgenerate

  assign preWrap = (preCnt == PRE_LAST);

  // prescaler and seconds counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preCnt <= '0;
      secCnt <= '0;
    end else if (strobe.loadDelay) begin
      preCnt <= '0;
      secCnt <= nextPair.delaySec;
    end else if (strobe.loadTout) begin
      preCnt <= '0;
      secCnt <= nextPair.toutSec;
    end else if (strobe.runCnt) begin
      if (preWrap) begin
        preCnt <= '0;
        secCnt <= secCnt - 6'd1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  // reset pulse length counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pulseCnt <= '0;
    else if (strobe.loadPulse) pulseCnt <= PULSE_INIT;
    else if (strobe.decPulse)  pulseCnt <= pulseCnt - 1'b1;
  end

  always_comb begin
    status.kickEdge      = wrEn && ctrlReg[3] && !wrData[3];
    status.cfgChange     = wrEn && (wrData[2:0] != ctrlReg[2:0]);
    status.nextEn        = nextPair.en;
    status.nextDelayZero = (nextPair.delaySec == 6'd0);
    status.secDone       = preWrap && (secCnt == 6'd1);
    status.pulseDone     = (pulseCnt == '0);
    status.cfgEn         = curPair.en;
  end

  p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |=> rdData == $past(wrData));

  p_prescale_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    preCnt <= PRE_LAST);

  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.runCnt |-> secCnt != 6'd0);

  p_table_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    curPair.en |-> (curPair.toutSec != 6'd0 && curPair.toutSec <= 6'd60 &&
                    curPair.delaySec <= 6'd60));

endmodule

// File: rtl/hbw_control.sv
module hbw_control
  import hbw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  wdStatus_t status,
  output wdStrobe_t strobe,
  output logic      wdReset
);

  wdState_t state;
  wdState_t stateNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    if (status.cfgChange) begin
      if (!status.nextEn) begin
        stateNext = ST_IDLE;
      end else if (status.nextDelayZero) begin
        stateNext = ST_ARM;
      end else begin
        stateNext        = ST_DELAY;
        strobe.loadDelay = 1'b1;
      end
    end else begin
      case (state)
        ST_ARM: begin
          if (status.kickEdge) begin
            stateNext       = ST_RUN;
            strobe.loadTout = 1'b1;
          end
        end
        ST_DELAY, ST_RUN: begin
          if (status.kickEdge) begin
            stateNext       = ST_RUN;
            strobe.loadTout = 1'b1;
          end else begin
            strobe.runCnt = 1'b1;
            if (status.secDone) begin
              stateNext        = ST_FIRE;
              strobe.loadPulse = 1'b1;
            end
          end
        end
        ST_FIRE: begin
          if (status.pulseDone) begin
            if (status.nextDelayZero) begin
              stateNext = ST_ARM;
            end else begin
              stateNext        = ST_DELAY;
              strobe.loadDelay = 1'b1;
            end
          end else begin
            strobe.decPulse = 1'b1;
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  assign wdReset = (state == ST_FIRE);

  p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !status.cfgEn |-> !wdReset);

  p_expire_fires_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.runCnt && status.secDone && !status.cfgChange && !status.kickEdge) |=> wdReset);

  p_kick_restarts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status.kickEdge && !status.cfgChange && (state != ST_IDLE) && (state != ST_FIRE))
      |=> (state == ST_RUN));

  p_arm_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARM && !status.kickEdge && !status.cfgChange) |=> (state == ST_ARM && !wdReset));

endmodule

// File: rtl/hb_watchdog.sv
module hb_watchdog
  import hbw_pkg::*;
#(
  parameter int TICKS_PER_SEC = 1000,
  parameter int RESET_CYCLES  = 16,
  parameter int VARIANT       = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       wdReset
);

  wdStrobe_t strobe;
  wdStatus_t status;

  hbw_datapath #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .RESET_CYCLES (RESET_CYCLES),
    .VARIANT      (VARIANT)
  ) datapath_i (
    .clk   (clk),
    .rst_n (rst_n),
    .wrEn  (wrEn),
    .wrData(wrData),
    .strobe(strobe),
    .status(status),
    .rdData(rdData)
  );

  hbw_control control_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .status (status),
    .strobe (strobe),
    .wdReset(wdReset)
  );

endmodule

// File: tb/hb_watchdog_tb_top.sv
module hb_watchdog_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TPS        = 5;
  localparam int RC         = 4;

  typedef struct {
    int    cyc;
    int    width;
    string tag;
  } expRise_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wrEnC = 1'b0;
  logic [7:0] wrDataC = 8'h00;
  logic [7:0] rdDataC;
  logic       wdResetC;
  logic       wrEnA = 1'b0;
  logic [7:0] wrDataA = 8'h00;
  logic [7:0] rdDataA;
  logic       wdResetA;

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;
  int riseCntA = 0;

  expRise_t expQ[$];
  expRise_t curExp;
  bit       haveCur = 1'b0;
  bit       prevC = 1'b0;
  bit       prevA = 1'b0;
  bit       monOn = 1'b0;
  int       highCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hb_watchdog #(.TICKS_PER_SEC(TPS), .RESET_CYCLES(RC), .VARIANT(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEnC), .wrData(wrDataC),
    .rdData(rdDataC), .wdReset(wdResetC));

  hb_watchdog #(.TICKS_PER_SEC(TPS), .RESET_CYCLES(RC), .VARIANT(0)) dutA_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEnA), .wrData(wrDataA),
    .rdData(rdDataA), .wdReset(wdResetA));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  // monitor: pops expected expiries for the table C instance
  always @(negedge clk) begin
    if (monOn) begin
      if (wdResetC && !prevC) begin
        highCnt = 1;
        if (expQ.size() == 0) begin
          check(1'b0, "R3 unexpected reset pulse", 1, 0);
          haveCur = 1'b0;
        end else begin
          curExp  = expQ.pop_front();
          haveCur = 1'b1;
          check(cyc == curExp.cyc, {curExp.tag, " rise cycle"}, cyc, curExp.cyc);
        end
      end else if (wdResetC) begin
        highCnt++;
      end else if (prevC && haveCur) begin
        if (curExp.width > 0)
          check(highCnt == curExp.width, {curExp.tag, " R7 pulse width"}, highCnt, curExp.width);
        haveCur = 1'b0;
      end
      if (wdResetA && !prevA) riseCntA++;
    end
    prevC = wdResetC;
    prevA = wdResetA;
  end

  task automatic wr(input bit selA, input logic [7:0] d, output int c);
    if (selA) begin wrEnA = 1'b1; wrDataA = d; end
    else      begin wrEnC = 1'b1; wrDataC = d; end
    @(negedge clk);
    c = cyc;
    wrEnA = 1'b0;
    wrEnC = 1'b0;
  endtask

  task automatic waitUntil(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic pushExp(input int c, input int w, input string tag);
    expRise_t e;
    e.cyc = c; e.width = w; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog timeout: actual running expected finished");
    finishRun();
  end

  initial begin
    int c0, c1, c2, c3, c4, cA, a0, a1, dummy, snapA;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    monOn = 1'b1;

    // R1 reset state
    check(rdDataC == 8'h03, "R1 rdData after reset", rdDataC, 8'h03);
    check(wdResetC == 1'b0, "R1 wdReset after reset", wdResetC, 0);
    check(rdDataA == 8'h03, "R1 rdData after reset (table A)", rdDataA, 8'h03);

    // R2 readback, R3 off codes stay silent
    wr(1'b0, 8'hF4, dummy);
    check(rdDataC == 8'hF4, "R2 readback F4", rdDataC, 8'hF4);
    repeat (300) @(negedge clk);
    wr(1'b0, 8'h00, dummy);
    check(rdDataC == 8'h00, "R2 readback 00", rdDataC, 8'h00);
    repeat (300) @(negedge clk);
    wr(1'b0, 8'h03, dummy);
    check(rdDataC == 8'h03, "R2 readback 03", rdDataC, 8'h03);
    repeat (50) @(negedge clk);
    check(wdResetC == 1'b0, "R3 off codes silent", wdResetC, 0);

    // R4 initial delay of code 2 (60 s)
    wr(1'b0, 8'h02, cA);
    pushExp(cA + 60*TPS, RC, "R4");
    waitUntil(cA + 60*TPS + 10);
    wr(1'b0, 8'h03, dummy);
    repeat (20) @(negedge clk);

    // R5 kick: set-only write ignored, clearing write restarts with 10 s
    wr(1'b0, 8'h07, c0);
    waitUntil(c0 + 100);
    wr(1'b0, 8'h0F, dummy);
    waitUntil(c0 + 280);
    wr(1'b0, 8'h07, c1);
    pushExp(c1 + 10*TPS, RC, "R5");
    // R7 back to the 60 s delay after the pulse
    pushExp(c1 + 10*TPS + RC + 60*TPS, RC, "R7");
    waitUntil(c1 + 10*TPS + RC + 60*TPS + 10);

    // R8 code change during delay phase restarts with the new delay (3 s)
    wr(1'b0, 8'h01, c2);
    pushExp(c2 + 3*TPS, RC, "R8");
    // R10 disable during the next pulse: width 1, then silence
    pushExp(c2 + 3*TPS + RC + 3*TPS, 1, "R10");
    waitUntil(c2 + 3*TPS + RC + 3*TPS);
    wr(1'b0, 8'h03, dummy);
    check(wdResetC == 1'b0, "R10 reset dropped after disable", wdResetC, 0);
    repeat (300) @(negedge clk);
    check(wdResetC == 1'b0, "R10 silent after disable", wdResetC, 0);

    // R6 zero-delay code 5 waits for a kick
    wr(1'b0, 8'h05, c3);
    repeat (200) @(negedge clk);
    check(wdResetC == 1'b0, "R6 no reset before first kick", wdResetC, 0);
    wr(1'b0, 8'h0D, dummy);
    wr(1'b0, 8'h05, c4);
    pushExp(c4 + 1*TPS, RC, "R6");
    repeat (TPS + RC + 200) @(negedge clk);
    check(wdResetC == 1'b0, "R6 waiting for kick after expiry", wdResetC, 0);
    check(rdDataC == 8'h05, "R2 readback 05", rdDataC, 8'h05);
    wr(1'b0, 8'h03, dummy);

    // R9 table A
    wr(1'b1, 8'h06, a0);
    waitUntil(a0 + 10*TPS - 1);
    check(wdResetA == 1'b0, "R9 table A code 6 before expiry", wdResetA, 0);
    @(negedge clk);
    check(wdResetA == 1'b1, "R9 table A code 6 expiry", wdResetA, 1);
    wr(1'b1, 8'h02, dummy);
    check(wdResetA == 1'b0, "R9 table A code 2 is off", wdResetA, 0);
    snapA = riseCntA;
    repeat (400) @(negedge clk);
    check(riseCntA == snapA, "R9 table A code 2 silent", riseCntA, snapA);
    wr(1'b1, 8'h05, a1);
    waitUntil(a1 + 1*TPS);
    check(wdResetA == 1'b1, "R9 table A code 5 one second", wdResetA, 1);
    wr(1'b1, 8'h03, dummy);

    repeat (20) @(negedge clk);
    check(expQ.size() == 0, "R4 all expected expiries seen", expQ.size(), 0);
    finishRun();
  end

endmodule